// File: doc/BRIEF.md
# Machine Security Configuration Register

This block holds the three machine-level security controls that steer an enhanced memory protection unit. The first, lockdown, redefines how the permission checker reads each entry's lock bit. The second, allowlist policy, makes machine-mode accesses that match no entry fault instead of passing. The third, rule-lock bypass, lets boot firmware edit locked entries. The block decodes CSR reads and writes from the core and drives the three bits continuously to the permission checker and to the entry-configuration write filter.

Lockdown and allowlist can only be raised by software. Only a PMP reset or the hardware reset lowers them. The bypass bit is ordinary read/write until it is zero while some protection entry reports its lock bit set. From then on it stays frozen at zero until a PMP reset. Parameters pick the register width, 64 or 32 bits, and how each bit is built. Each sticky bit can be hardwired to 0, hardwired to 1, or sticky. The bypass bit can be writable or read-only zero. On a 32-bit build the upper half of the register has its own address and reads as all zeros.

Top module: `msec_cfg_reg`

## Requirements
- R1: After `rst_n` is released, with sticky modes and a writable bypass bit, a read of address 0x747 returns 0 and all three control outputs are 0.
- R2: Address 0x747 reads lockdown in bit 0, allowlist in bit 1 and bypass in bit 2. Every other bit reads 0 whatever is written. Any address that is not decoded gives `csr_rdata` = 0 and `csr_illegal` = 0.
- R3: In sticky mode, a write sets lockdown to the OR of write-data bit 0 and its current value, so it never goes from 1 to 0 by a write.
- R4: In sticky mode, a write sets allowlist to the OR of write-data bit 1 and its current value, so it never goes from 1 to 0 by a write.
- R5: A write loads bypass from write-data bit 2. The exception is when bypass is 0 and `any_entry_locked` is 1: the write is then ignored. A bypass of 1 may still be cleared while entries are locked.
- R6: A one-cycle `pmp_rst` pulse clears all sticky and bypass bits on the next edge, takes priority over a write in the same cycle, and releases a frozen bypass bit.
- R7: A decoded access whose `csr_priv` is not 2'b11 (machine) raises `csr_illegal` in the same cycle, reads 0, and changes no bit.
- R8: A legal write changes the outputs at the first rising edge after the strobe. A read is combinational and shows the value before that edge.
- R9: With XLEN = 32, address 0x757 is decoded: it reads 0 and writes to it change nothing. With XLEN = 64, 0x757 is not decoded.
- R10: A bit hardwired to 0 or 1 always reads and drives its fixed value and ignores writes. A read-only bypass bit always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset (also acts as a PMP reset) |
| pmp_rst | input | 1 | Synchronous PMP reset request, active high |
| csr_en | input | 1 | CSR access strobe |
| csr_we | input | 1 | Access is a write when high |
| csr_addr | input | 12 | CSR address |
| csr_priv | input | 2 | Privilege of the access, 2'b11 = machine |
| csr_wdata | input | XLEN | Write data |
| any_entry_locked | input | 1 | High when any protection entry, enabled or not, has its lock bit set |
| csr_rdata | output | XLEN | Read data, combinational |
| csr_illegal | output | 1 | Decoded access from below machine mode |
| lockdown_en | output | 1 | Lockdown control bit |
| allowlist_en | output | 1 | Allowlist-policy control bit |
| bypass_en | output | 1 | Rule-lock bypass control bit |

## Verification
Assertions check on every cycle the properties that hold between two cycles. A set sticky bit never drops without a PMP reset. A zero bypass bit stays zero while an entry is locked. A PMP reset clears every sticky bit by the next edge. An illegal access leaves the register unchanged, and the reserved read bits are always zero. The bench's scenarios are needed for the rest. These are the reset values, the field positions of the read data, the one-edge delay of a write against a combinational read, the per-address decode that differs between the 32-bit and 64-bit builds, and the hardwired variants, which a second instance in the bench covers. A long sweep drives write patterns, lock states, privileges and PMP resets against an arithmetic model of the register.

// File: rtl/msec_pkg.sv
package msec_pkg;
  typedef enum logic [1:0] {
    BIT_FIXED0 = 2'd0,
    BIT_FIXED1 = 2'd1,
    BIT_STICKY = 2'd2
  } bit_mode_e;

  localparam logic [11:0] ADDR_LO = 12'h747;
  localparam logic [11:0] ADDR_HI = 12'h757;
  localparam logic [1:0]  PRIV_M  = 2'b11;

  localparam int POS_LOCKDOWN = 0;
  localparam int POS_ALLOW    = 1;
  localparam int POS_BYPASS   = 2;
  localparam int NUM_CTRL     = 3;
endpackage

// File: rtl/msec_decode.sv
module msec_decode #(
  parameter int XLEN = 64
) (
  input  logic        csr_en,
  input  logic        csr_we,
  input  logic [11:0] csr_addr,
  input  logic [1:0]  csr_priv,
  output logic        sel_lo,
  output logic        sel_hi,
  output logic        illegal,
  output logic        wr_ok
);
  import msec_pkg::*;

  logic is_m;

  assign sel_lo = csr_en && (csr_addr == ADDR_LO);

  generate
    if (XLEN == 32) begin : g_hi_view
      assign sel_hi = csr_en && (csr_addr == ADDR_HI);
    end else begin : g_no_hi
      assign sel_hi = 1'b0;
    end
  endgenerate

  assign is_m    = (csr_priv == PRIV_M);
  assign illegal = (sel_lo || sel_hi) && !is_m;
  assign wr_ok   = sel_lo && csr_we && is_m;
endmodule

// File: rtl/msec_sticky_bit.sv
module msec_sticky_bit #(
  parameter msec_pkg::bit_mode_e MODE = msec_pkg::BIT_STICKY
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pmp_rst,
  input  logic wr_en,
  input  logic wr_bit,
  output logic q
);
  import msec_pkg::*;

  logic unused_inputs;
  assign unused_inputs = clk ^ rst_n ^ pmp_rst ^ wr_en ^ wr_bit;

  generate
    if (MODE == BIT_STICKY) begin : g_sticky
      logic q_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q_r <= 1'b0;
        else if (pmp_rst) q_r <= 1'b0;
        else if (wr_en)   q_r <= q_r | wr_bit;
      end
      assign q = q_r;

      // R3 and R4: a set bit survives every cycle without a PMP reset
      a_r3_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q_r && !pmp_rst) |=> q_r);
      a_r6_pmp_clears_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        pmp_rst |=> !q_r);
    end else if (MODE == BIT_FIXED1) begin : g_one
      assign q = 1'b1;
    end else begin : g_zero
      assign q = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/msec_bypass_bit.sv
module msec_bypass_bit #(
  parameter bit WRITABLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pmp_rst,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic any_locked,
  output logic q
);
  logic unused_inputs;
  assign unused_inputs = clk ^ rst_n ^ pmp_rst ^ wr_en ^ wr_bit ^ any_locked;

  generate
    if (WRITABLE) begin : g_rw
      logic q_r;
      logic frozen;
      assign frozen = !q_r && any_locked;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 q_r <= 1'b0;
        else if (pmp_rst)           q_r <= 1'b0;
        else if (wr_en && !frozen)  q_r <= wr_bit;
      end
      assign q = q_r;

      a_r5_frozen_stays_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_r && any_locked && !pmp_rst) |=> !q_r);
      a_r6_pmp_clears_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        pmp_rst |=> !q_r);
    end else begin : g_ro
      assign q = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/msec_cfg_reg.sv
module msec_cfg_reg #(
  parameter int                  XLEN            = 64,
  parameter msec_pkg::bit_mode_e LOCKDOWN_MODE   = msec_pkg::BIT_STICKY,
  parameter msec_pkg::bit_mode_e ALLOW_MODE      = msec_pkg::BIT_STICKY,
  parameter bit                  BYPASS_WRITABLE = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pmp_rst,
  input  logic            csr_en,
  input  logic            csr_we,
  input  logic [11:0]     csr_addr,
  input  logic [1:0]      csr_priv,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic            any_entry_locked,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_illegal,
  output logic            lockdown_en,
  output logic            allowlist_en,
  output logic            bypass_en
);
  import msec_pkg::*;

  localparam int PAD_W = XLEN - NUM_CTRL;

  logic sel_lo, sel_hi, wr_ok;
  logic [NUM_CTRL-1:0] ctrl;
  logic unused_wdata;

  assign unused_wdata = ^{csr_wdata[XLEN-1:NUM_CTRL], sel_hi};

  msec_decode #(.XLEN(XLEN)) u_decode (
    .csr_en   (csr_en),
    .csr_we   (csr_we),
    .csr_addr (csr_addr),
    .csr_priv (csr_priv),
    .sel_lo   (sel_lo),
    .sel_hi   (sel_hi),
    .illegal  (csr_illegal),
    .wr_ok    (wr_ok)
  );

  msec_sticky_bit #(.MODE(LOCKDOWN_MODE)) u_lockdown (
    .clk(clk), .rst_n(rst_n), .pmp_rst(pmp_rst),
    .wr_en(wr_ok), .wr_bit(csr_wdata[POS_LOCKDOWN]), .q(ctrl[POS_LOCKDOWN])
  );

  msec_sticky_bit #(.MODE(ALLOW_MODE)) u_allow (
    .clk(clk), .rst_n(rst_n), .pmp_rst(pmp_rst),
    .wr_en(wr_ok), .wr_bit(csr_wdata[POS_ALLOW]), .q(ctrl[POS_ALLOW])
  );

  msec_bypass_bit #(.WRITABLE(BYPASS_WRITABLE)) u_bypass (
    .clk(clk), .rst_n(rst_n), .pmp_rst(pmp_rst),
    .wr_en(wr_ok), .wr_bit(csr_wdata[POS_BYPASS]),
    .any_locked(any_entry_locked), .q(ctrl[POS_BYPASS])
  );

  assign lockdown_en  = ctrl[POS_LOCKDOWN];
  assign allowlist_en = ctrl[POS_ALLOW];
  assign bypass_en    = ctrl[POS_BYPASS];

  // Upper-half view (32-bit builds) and undecoded addresses read zero.
  always_comb begin
    if (sel_lo && !csr_illegal) csr_rdata = {{PAD_W{1'b0}}, ctrl};
    else                        csr_rdata = '0;
  end

  a_r7_illegal_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_illegal && !pmp_rst) |=> $stable(ctrl));
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[XLEN-1:NUM_CTRL] == '0);
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (LOCKDOWN_MODE == BIT_STICKY && csr_en && csr_we && !csr_illegal &&
     csr_addr == ADDR_LO && csr_wdata[POS_LOCKDOWN] && !pmp_rst) |=> lockdown_en);
endmodule

// File: tb/msec_cfg_reg_bench.sv
`timescale 1ns/1ps
module msec_cfg_reg_bench;
  import msec_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pmp_rst = 1'b0;
  logic        csr_en = 1'b0;
  logic        csr_we = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [1:0]  csr_priv = 2'b11;
  logic [63:0] csr_wdata = '0;
  logic        locked = 1'b0;

  logic [63:0] rdata;
  logic        illegal, ld, al, by;
  logic [31:0] a_rdata;
  logic        a_illegal, a_ld, a_al, a_by;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  msec_cfg_reg u_msec_cfg_reg (
    .clk(clk), .rst_n(rst_n), .pmp_rst(pmp_rst), .csr_en(csr_en), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_priv(csr_priv), .csr_wdata(csr_wdata),
    .any_entry_locked(locked), .csr_rdata(rdata), .csr_illegal(illegal),
    .lockdown_en(ld), .allowlist_en(al), .bypass_en(by)
  );

  msec_cfg_reg #(.XLEN(32), .LOCKDOWN_MODE(BIT_FIXED1), .ALLOW_MODE(BIT_FIXED0),
                 .BYPASS_WRITABLE(1'b0)) u_alt (
    .clk(clk), .rst_n(rst_n), .pmp_rst(pmp_rst), .csr_en(csr_en), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_priv(csr_priv), .csr_wdata(csr_wdata[31:0]),
    .any_entry_locked(locked), .csr_rdata(a_rdata), .csr_illegal(a_illegal),
    .lockdown_en(a_ld), .allowlist_en(a_al), .bypass_en(a_by)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] addr, input logic [1:0] priv,
                    input logic [63:0] data);
    @(negedge clk);
    csr_en = 1'b1; csr_we = 1'b1; csr_addr = addr; csr_priv = priv; csr_wdata = data;
    @(negedge clk);
    csr_en = 1'b0; csr_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] addr, input logic [1:0] priv);
    @(negedge clk);
    csr_en = 1'b1; csr_we = 1'b0; csr_addr = addr; csr_priv = priv;
    #1;
  endtask

  task automatic pmp_pulse();
    @(negedge clk);
    pmp_rst = 1'b1;
    @(negedge clk);
    pmp_rst = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(12'h747, 2'b11);
    check(rdata == 64'h0 && {by, al, ld} == 3'b000, "R1 reset", rdata, 0);
    // R10 hardwired instance after reset
    check(a_rdata == 32'h1 && a_ld && !a_al && !a_by, "R10 fixed values", a_rdata, 1);

    // R8 read before edge, write visible after edge
    @(negedge clk);
    csr_en = 1'b1; csr_we = 1'b1; csr_addr = 12'h747; csr_priv = 2'b11; csr_wdata = 64'h1;
    #1;
    check(rdata == 64'h0 && !ld, "R8 before edge", rdata, 0);
    @(negedge clk);
    csr_en = 1'b0; csr_we = 1'b0;
    check(ld == 1'b1, "R8 after edge", {63'b0, ld}, 1);

    // R3 lockdown cannot be cleared by a write
    wr(12'h747, 2'b11, 64'h0);
    check(ld == 1'b1, "R3 sticky lockdown", {63'b0, ld}, 1);

    // R4 allowlist set then held
    wr(12'h747, 2'b11, 64'h2);
    wr(12'h747, 2'b11, 64'h0);
    rd(12'h747, 2'b11);
    check(rdata == 64'h3, "R4 sticky allowlist", rdata, 3);

    // R5 bypass writable, clearable while locked, then frozen
    locked = 1'b0;
    wr(12'h747, 2'b11, 64'h4);
    check(by == 1'b1, "R5 bypass set", {63'b0, by}, 1);
    locked = 1'b1;
    wr(12'h747, 2'b11, 64'h0);
    check(by == 1'b0, "R5 bypass cleared while locked", {63'b0, by}, 0);
    wr(12'h747, 2'b11, 64'h4);
    check(by == 1'b0, "R5 bypass frozen", {63'b0, by}, 0);

    // R2 reserved bits: all-ones write reads only the control bits
    locked = 1'b0;
    wr(12'h747, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(12'h747, 2'b11);
    check(rdata == 64'h7, "R2 field layout", rdata, 7);

    // R6 PMP reset clears all and wins over a simultaneous write
    @(negedge clk);
    pmp_rst = 1'b1; csr_en = 1'b1; csr_we = 1'b1; csr_addr = 12'h747;
    csr_priv = 2'b11; csr_wdata = 64'h7;
    @(negedge clk);
    pmp_rst = 1'b0; csr_en = 1'b0; csr_we = 1'b0;
    check({by, al, ld} == 3'b000, "R6 pmp reset clears", {61'b0, by, al, ld}, 0);
    locked = 1'b1;
    wr(12'h747, 2'b11, 64'h4);
    check(by == 1'b0, "R6 frozen after reset with lock", {63'b0, by}, 0);
    pmp_pulse();
    locked = 1'b0;
    wr(12'h747, 2'b11, 64'h4);
    check(by == 1'b1, "R6 released after reset", {63'b0, by}, 1);

    // R7 lower-privilege access
    @(negedge clk);
    csr_en = 1'b1; csr_we = 1'b1; csr_addr = 12'h747; csr_priv = 2'b01; csr_wdata = 64'h3;
    #1;
    check(illegal == 1'b1 && rdata == 64'h0, "R7 illegal flagged", {63'b0, illegal}, 1);
    @(negedge clk);
    csr_en = 1'b0; csr_we = 1'b0;
    check({by, al, ld} == 3'b100, "R7 no change", {61'b0, by, al, ld}, 4);

    // R2 undecoded addresses
    rd(12'h748, 2'b00);
    check(rdata == 64'h0 && !illegal, "R2 other address", {63'b0, illegal}, 0);
    // R9 64-bit build does not decode 0x757
    rd(12'h757, 2'b00);
    check(rdata == 64'h0 && !illegal, "R9 no upper view at 64", {63'b0, illegal}, 0);
    // R9 32-bit build decodes 0x757
    check(a_rdata == 32'h0 && a_illegal, "R9 upper view decoded", {63'b0, a_illegal}, 1);
    rd(12'h757, 2'b11);
    check(a_rdata == 32'h0 && !a_illegal, "R9 upper view reads zero", a_rdata, 0);
    wr(12'h757, 2'b11, 64'hFFFF_FFFF);
    rd(12'h747, 2'b11);
    check(a_rdata == 32'h1, "R9 upper write ignored", a_rdata, 1);

    // R10 hardwired bits ignore writes
    wr(12'h747, 2'b11, 64'h6);
    check(a_ld && !a_al && !a_by, "R10 writes ignored", {61'b0, a_by, a_al, a_ld}, 1);

    // Sweep against a model
    pmp_pulse();
    m = 3'b000;
    for (int i = 0; i < 120; i++) begin
      logic [2:0] v;
      logic lk;
      v  = 3'((i * 5 + 3) % 8);
      lk = ((i / 3) % 2) == 1;
      locked = lk;
      if (i % 13 == 12) begin
        pmp_pulse();
        m = 3'b000;
      end else if (i % 7 == 6) begin
        wr(12'h747, 2'b10, {61'b0, v});
      end else begin
        wr(12'h747, 2'b11, {61'b0, v});
        m[0] = m[0] | v[0];
        m[1] = m[1] | v[1];
        if (!(m[2] == 1'b0 && lk)) m[2] = v[2];
      end
      rd(12'h747, 2'b11);
      check(rdata == {61'b0, m}, "R3 R4 R5 sweep", rdata, {61'b0, m});
    end

    csr_en = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule